// File: doc/BRIEF.md
# Multi-Region Data Memory Arbiter

This block connects three bus masters (a processor port, a DMA read port and a DMA write port) to a data memory made of four independent regions: an I/O register region, an SRAM region, a mapped EEPROM region and a spare region. Each region is a small register array inside the block and has its own read latency and its own burst rate. Masters that address different regions are served in the same cycle. Masters that address the same region are arbitrated by fixed priority.

Each master drives a request, an address, write data and a write enable. It receives a grant in the cycle its access is accepted. For a read, it later receives a one-cycle read-valid pulse together with the read data. A write takes effect at the clock edge that ends its grant cycle. A read that is in flight in a multi-cycle region keeps that region for its owner until the data returns. A master that keeps its request asserted can therefore stream a burst without being interrupted.

Top module: `dmx_fabric`

## Requirements
- R1: Addresses are 8 bits wide. Bits [7:4] select the region: 0x0 is I/O, 0x4 is SRAM, 0x8 is EEPROM and 0xC is spare. Bits [3:0] select one of 16 byte entries. An address outside these four windows is never granted.
- R2: A request to a free region is granted combinationally in the same cycle. A write is stored at the end of its grant cycle, so a read of that entry granted in the next cycle returns the new value.
- R3: A read granted in cycle t raises read-valid for exactly one cycle, with the read data, in cycle t+1 for the I/O and spare regions, in cycle t+2 for SRAM and in cycle t+3 for EEPROM.
- R4: Masters that target different regions are all granted in the same cycle.
- R5: When several masters request a free region in the same cycle, the processor port (bit 0) wins, then DMA read (bit 1), then DMA write (bit 2). A master that loses is granted in a later cycle while it keeps its request asserted.
- R6: While a read is in flight in SRAM or EEPROM, up to the cycle before its data returns, only the master that issued it can be granted in that region.
- R7: A master that keeps requesting SRAM reads is granted in consecutive cycles, and its read data returns on consecutive cycles.
- R8: After an EEPROM read is granted, no grant is given in the EEPROM region in the following cycle. A burst therefore runs at one beat every second cycle.
- R9: A master with a read outstanding in one region is not granted in another region until the cycle after its last read-valid pulse.
- R10: Read-valid and read data go only to the master that issued the read, even when several regions return data in the same cycle.
- R11: Reset is synchronous and active high. While reset is high, no grant is given. After reset, reads issued before it never return, and all memory entries read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 3 | Request per master (bit 0 processor, bit 1 DMA read, bit 2 DMA write) |
| m_addr | input | 24 | Address per master, 8 bits each, master m at [8m+7:8m] |
| m_wdata | input | 24 | Write data per master, 8 bits each |
| m_we | input | 3 | Write enable per master |
| m_gnt | output | 3 | Grant per master, valid in the request cycle |
| m_rvalid | output | 3 | One-cycle read-data valid per master |
| m_rdata | output | 24 | Read data per master, 8 bits each |

## Verification
Two functions can fall in the same cycle: a region returning read data to one master, and a grant being decided for another master in the same region or in a different region. The bench provokes both overlaps. In one case, the processor requests SRAM while a DMA read burst is still returning data there. In the other, all three masters read three different regions at once, so their returns arrive in staggered cycles. Each table row states the grant vector and the read-valid vector expected in that cycle, and the data expected for every master that has a pulse. A grant that lands one cycle early or late, or data routed to the wrong master, shows as a mismatch in that row.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
    localparam int NM = 3;   // masters: 0 processor, 1 DMA read, 2 DMA write
    localparam int NR = 4;   // regions: 0 I/O, 1 SRAM, 2 EEPROM, 3 spare
    typedef logic [1:0] mid_t;
endpackage

// File: rtl/dmx_decode.sv
module dmx_decode
    import dmx_pkg::*;
#(
    parameter int AW = 8,
    parameter int IW = 4,
    parameter logic [NR*AW-1:0] BASES = {8'hC0, 8'h80, 8'h40, 8'h00}
) (
    input  logic [AW-1:0] addr,
    output logic [NR-1:0] hit
);
    localparam int TW = AW - IW;

    for (genvar r = 0; r < NR; r++) begin : g_win
        assign hit[r] = (addr[AW-1:IW] == BASES[r*AW+IW +: TW]);
    end
endmodule

// File: rtl/dmx_region.sv
module dmx_region
    import dmx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int IW  = 4,
    parameter int LAT = 1,
    parameter int GAP = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NM-1:0]   hit,
    input  logic [NM-1:0]   we,
    input  logic [NM*IW-1:0] idx,
    input  logic [NM*DW-1:0] wdata,
    input  logic [NM-1:0]   elig,
    output logic [NM-1:0]   gnt,
    output logic            ret_v,
    output mid_t            ret_mid,
    output logic [DW-1:0]   ret_data
);
    localparam int DEPTH = 2 ** IW;

    typedef struct packed {
        logic                       lock;
        mid_t                       own;
        logic [1:0]                 gap;
        logic [LAT-1:0]             v;
        logic [LAT-1:0][1:0]        mid;
        logic [LAT-1:0][DW-1:0]     data;
        logic [DEPTH-1:0][DW-1:0]   mem;
    } rst_t;

    rst_t s_d, s_q;
    logic acc;
    mid_t am;
    logic [IW-1:0] ai;

    always_comb begin
        s_d = s_q;
        gnt = '0;
        acc = 1'b0;
        am  = '0;
        if (s_q.lock) begin
            if (hit[s_q.own] && s_q.gap == '0) begin
                acc = 1'b1;
                am  = s_q.own;
            end
        end else begin
            for (int m = NM - 1; m >= 0; m--) begin
                if (hit[m] && elig[m]) begin
                    acc = 1'b1;
                    am  = mid_t'(m);
                end
            end
        end
        ai = idx[int'(am)*IW +: IW];

        s_d.v = s_q.v >> 1;
        for (int i = 0; i < LAT - 1; i++) begin
            s_d.mid[i]  = s_q.mid[i+1];
            s_d.data[i] = s_q.data[i+1];
        end
        s_d.mid[LAT-1]  = '0;
        s_d.data[LAT-1] = '0;
        if (s_q.gap != '0) s_d.gap = s_q.gap - 2'd1;

        if (acc) begin
            gnt[am] = 1'b1;
            s_d.own = am;
            if (we[am]) begin
                s_d.mem[ai] = wdata[int'(am)*DW +: DW];
            end else begin
                s_d.v[LAT-1]    = 1'b1;
                s_d.mid[LAT-1]  = am;
                s_d.data[LAT-1] = s_q.mem[ai];
                s_d.gap         = 2'(GAP - 1);
            end
        end
        s_d.lock = (|(s_d.v >> 1)) || (s_d.gap != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign ret_v    = s_q.v[0];
    assign ret_mid  = s_q.mid[0];
    assign ret_data = s_q.data[0];

    p_single_winner_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
    p_owner_only_r6: assert property (@(posedge clk) disable iff (rst)
        s_q.lock |-> ((gnt & ~(NM'(1) << s_q.own)) == '0));
    p_beat_spacing_r8: assert property (@(posedge clk) disable iff (rst)
        (s_q.gap != '0) |-> (gnt == '0));
endmodule

// File: rtl/dmx_fabric.sv
module dmx_fabric
    import dmx_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter int IW = 4,
    parameter logic [NR*AW-1:0] BASES = {8'hC0, 8'h80, 8'h40, 8'h00},
    parameter logic [NR*2-1:0]  LATS  = {2'd1, 2'd3, 2'd2, 2'd1},
    parameter logic [NR*2-1:0]  GAPS  = {2'd1, 2'd2, 2'd1, 2'd1}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NM-1:0]     m_req,
    input  logic [NM*AW-1:0]  m_addr,
    input  logic [NM*DW-1:0]  m_wdata,
    input  logic [NM-1:0]     m_we,
    output logic [NM-1:0]     m_gnt,
    output logic [NM-1:0]     m_rvalid,
    output logic [NM*DW-1:0]  m_rdata
);
    typedef struct packed {
        logic [NM-1:0][2:0] pend;
        logic [NM-1:0][1:0] last;
    } fst_t;

    fst_t f_d, f_q;

    logic [NR-1:0]    hit_m  [NM];
    logic [NR-1:0]    ret_to [NM];
    logic [NM-1:0]    rhit   [NR];
    logic [NM-1:0]    relig  [NR];
    logic [NM-1:0]    rgnt   [NR];
    logic [NR-1:0]    rv;
    mid_t             rmid   [NR];
    logic [DW-1:0]    rdat   [NR];
    logic [NM*IW-1:0] idx_all;

    for (genvar m = 0; m < NM; m++) begin : g_mst
        assign idx_all[m*IW +: IW] = m_addr[m*AW +: IW];
        dmx_decode #(.AW(AW), .IW(IW), .BASES(BASES)) u_dec (
            .addr (m_addr[m*AW +: AW]),
            .hit  (hit_m[m])
        );
    end

    for (genvar r = 0; r < NR; r++) begin : g_rgn
        dmx_region #(
            .DW(DW), .IW(IW),
            .LAT(int'(LATS[r*2 +: 2])),
            .GAP(int'(GAPS[r*2 +: 2]))
        ) u_rgn (
            .clk      (clk),
            .rst      (rst),
            .hit      (rhit[r]),
            .we       (m_we),
            .idx      (idx_all),
            .wdata    (m_wdata),
            .elig     (relig[r]),
            .gnt      (rgnt[r]),
            .ret_v    (rv[r]),
            .ret_mid  (rmid[r]),
            .ret_data (rdat[r])
        );
    end

    always_comb begin
        for (int r = 0; r < NR; r++) begin
            for (int m = 0; m < NM; m++) begin
                rhit[r][m]  = m_req[m] & hit_m[m][r] & ~rst;
                relig[r][m] = (f_q.pend[m] == '0) || (f_q.last[m] == 2'(r));
            end
        end
        m_gnt    = '0;
        m_rvalid = '0;
        m_rdata  = '0;
        for (int m = 0; m < NM; m++) ret_to[m] = '0;
        for (int r = 0; r < NR; r++) begin
            m_gnt = m_gnt | rgnt[r];
            for (int m = 0; m < NM; m++) begin
                if (rv[r] && rmid[r] == mid_t'(m)) begin
                    m_rvalid[m]          = 1'b1;
                    m_rdata[m*DW +: DW]  = rdat[r];
                    ret_to[m][r]         = 1'b1;
                end
            end
        end
        f_d = f_q;
        for (int m = 0; m < NM; m++) begin
            if (m_gnt[m] && !m_we[m]) f_d.pend[m] = f_d.pend[m] + 3'd1;
            if (m_rvalid[m])          f_d.pend[m] = f_d.pend[m] - 3'd1;
            if (m_gnt[m]) begin
                for (int r = 0; r < NR; r++) begin
                    if (hit_m[m][r]) f_d.last[m] = 2'(r);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) f_q <= '0;
        else     f_q <= f_d;
    end

    for (genvar m = 0; m < NM; m++) begin : g_chk
        p_no_cross_region_r9: assert property (@(posedge clk) disable iff (rst)
            (f_q.pend[m] != '0 && !hit_m[m][f_q.last[m]]) |-> !m_gnt[m]);
        p_one_return_r10: assert property (@(posedge clk) disable iff (rst)
            $onehot0(ret_to[m]));
    end

    p_reset_flush_r11: assert property (@(posedge clk)
        rst |=> (m_rvalid == '0));
endmodule

// File: tb/test_dmx_fabric.sv
module test_dmx_fabric;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  m_req, m_we, m_gnt, m_rvalid;
    logic [23:0] m_addr, m_wdata, m_rdata;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmx_fabric i_dmx_fabric (
        .clk(clk), .rst(rst), .m_req(m_req), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_we(m_we), .m_gnt(m_gnt),
        .m_rvalid(m_rvalid), .m_rdata(m_rdata)
    );

    typedef struct packed {
        logic [2:0]  req;
        logic [2:0]  we;
        logic [23:0] addr;
        logic [23:0] wd;
        logic [2:0]  gnt;
        logic [2:0]  rv;
        logic [23:0] rd;
        logic [3:0]  rq;
    } row_t;

    // Fields per master packed as {DMA write, DMA read, processor}.
    // Rows 0-4: R4 parallel + R3 latencies; 5-8: R5 priority; 9-10: R10 routing;
    // 11-13, 19: R6 lock; 16-20: R7 SRAM burst; 23-28: R8 EEPROM burst;
    // 29-34: R9 cross-region hold; 35-38: R2 write then read.
    localparam int NROW = 39;
    localparam row_t TAB [NROW] = '{
        '{3'b111, 3'b111, 24'h85_42_03, 24'hC3_B2_A1, 3'b111, 3'b000, 24'h0, 4'd4},
        '{3'b111, 3'b000, 24'h85_42_03, 24'h0,        3'b111, 3'b000, 24'h0, 4'd4},
        '{3'b000, 3'b000, 24'h0, 24'h0, 3'b000, 3'b001, 24'h00_00_A1, 4'd3},
        '{3'b000, 3'b000, 24'h0, 24'h0, 3'b000, 3'b010, 24'h00_B2_00, 4'd3},
        '{3'b000, 3'b000, 24'h0, 24'h0, 3'b000, 3'b100, 24'hC3_00_00, 4'd3},
        '{3'b111, 3'b111, 24'hC2_C1_C0, 24'h33_22_11, 3'b001, 3'b000, 24'h0, 4'd5},
        '{3'b110, 3'b110, 24'hC2_C1_C0, 24'h33_22_11, 3'b010, 3'b000, 24'h0, 4'd5},
        '{3'b100, 3'b100, 24'hC2_C1_C0, 24'h33_22_11, 3'b100, 3'b000, 24'h0, 4'd5},
        '{3'b011, 3'b000, 24'h00_C1_C0, 24'h0, 3'b001, 3'b000, 24'h0, 4'd5},
        '{3'b010, 3'b000, 24'h00_C1_C0, 24'h0, 3'b010, 3'b001, 24'h00_00_11, 4'd10},
        '{3'b000, 3'b000, 24'h0, 24'h0, 3'b000, 3'b010, 24'h00_22_00, 4'd10},
        '{3'b010, 3'b000, 24'h00_42_00, 24'h0, 3'b010, 3'b000, 24'h0, 4'd6},
        '{3'b001, 3'b000, 24'h00_00_40, 24'h0, 3'b000, 3'b000, 24'h0, 4'd6},
        '{3'b001, 3'b000, 24'h00_00_40, 24'h0, 3'b001, 3'b010, 24'h00_B2_00, 4'd6},
        '{3'b000, 3'b000, 24'h0, 24'h0, 3'b000, 3'b000, 24'h0, 4'd3},
        '{3'b000, 3'b000, 24'h0, 24'h0, 3'b000, 3'b001, 24'h0, 4'd3},
        '{3'b010, 3'b000, 24'h00_41_00, 24'h0, 3'b010, 3'b000, 24'h0, 4'd7},
        '{3'b011, 3'b000, 24'h00_42_40, 24'h0, 3'b010, 3'b000, 24'h0, 4'd7},
        '{3'b011, 3'b000, 24'h00_43_40, 24'h0, 3'b010, 3'b010, 24'h0, 4'd7},
        '{3'b001, 3'b000, 24'h00_00_40, 24'h0, 3'b000, 3'b010, 24'h00_B2_00, 4'd6},
        '{3'b001, 3'b000, 24'h00_00_40, 24'h0, 3'b001, 3'b010, 24'h0, 4'd7},
        '{3'b000, 3'b000, 24'h0, 24'h0, 3'b000, 3'b000, 24'h0, 4'd3},
        '{3'b000, 3'b000, 24'h0, 24'h0, 3'b000, 3'b001, 24'h0, 4'd3},
        '{3'b100, 3'b000, 24'h84_00_00, 24'h0, 3'b100, 3'b000, 24'h0, 4'd8},
        '{3'b100, 3'b000, 24'h85_00_00, 24'h0, 3'b000, 3'b000, 24'h0, 4'd8},
        '{3'b100, 3'b000, 24'h85_00_00, 24'h0, 3'b100, 3'b000, 24'h0, 4'd8},
        '{3'b000, 3'b000, 24'h0, 24'h0, 3'b000, 3'b100, 24'h0, 4'd3},
        '{3'b000, 3'b000, 24'h0, 24'h0, 3'b000, 3'b000, 24'h0, 4'd8},
        '{3'b000, 3'b000, 24'h0, 24'h0, 3'b000, 3'b100, 24'hC3_00_00, 4'd8},
        '{3'b100, 3'b000, 24'h85_00_00, 24'h0, 3'b100, 3'b000, 24'h0, 4'd9},
        '{3'b100, 3'b000, 24'h03_00_00, 24'h0, 3'b000, 3'b000, 24'h0, 4'd9},
        '{3'b100, 3'b000, 24'h03_00_00, 24'h0, 3'b000, 3'b000, 24'h0, 4'd9},
        '{3'b100, 3'b000, 24'h03_00_00, 24'h0, 3'b000, 3'b100, 24'hC3_00_00, 4'd9},
        '{3'b100, 3'b000, 24'h03_00_00, 24'h0, 3'b100, 3'b000, 24'h0, 4'd9},
        '{3'b000, 3'b000, 24'h0, 24'h0, 3'b000, 3'b100, 24'hA1_00_00, 4'd9},
        '{3'b001, 3'b001, 24'h00_00_44, 24'h00_00_5A, 3'b001, 3'b000, 24'h0, 4'd2},
        '{3'b001, 3'b000, 24'h00_00_44, 24'h0, 3'b001, 3'b000, 24'h0, 4'd2},
        '{3'b000, 3'b000, 24'h0, 24'h0, 3'b000, 3'b000, 24'h0, 4'd2},
        '{3'b000, 3'b000, 24'h0, 24'h0, 3'b000, 3'b001, 24'h00_00_5A, 4'd2}
    };

    task automatic chk(input string what, input int rq, input logic [23:0] act,
                       input logic [23:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] req, input logic [2:0] we,
                         input logic [23:0] addr, input logic [23:0] wd);
        m_req = req; m_we = we; m_addr = addr; m_wdata = wd;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        drive(3'b000, 3'b000, 24'h0, 24'h0);
        @(negedge clk);
        // R11: no grant while reset is high
        drive(3'b111, 3'b000, 24'hC0_40_03, 24'h0);
        #1;
        chk("R11 gnt in reset", 11, {21'h0, m_gnt}, 24'h0);
        chk("R11 rvalid in reset", 11, {21'h0, m_rvalid}, 24'h0);
        @(negedge clk);
        rst = 1'b0;
        drive(3'b000, 3'b000, 24'h0, 24'h0);

        for (int i = 0; i < NROW; i++) begin
            @(negedge clk);
            drive(TAB[i].req, TAB[i].we, TAB[i].addr, TAB[i].wd);
            #1;
            chk($sformatf("row %0d grant", i), int'(TAB[i].rq),
                {21'h0, m_gnt}, {21'h0, TAB[i].gnt});
            chk($sformatf("row %0d rvalid", i), int'(TAB[i].rq),
                {21'h0, m_rvalid}, {21'h0, TAB[i].rv});
            for (int m = 0; m < 3; m++) begin
                if (TAB[i].rv[m])
                    chk($sformatf("row %0d rdata m%0d", i, m), int'(TAB[i].rq),
                        {16'h0, m_rdata[m*8 +: 8]}, {16'h0, TAB[i].rd[m*8 +: 8]});
            end
        end

        // R1: address outside every window is never granted
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            drive(3'b001, 3'b000, 24'h00_00_20, 24'h0);
            #1;
            chk("R1 unmapped grant", 1, {21'h0, m_gnt}, 24'h0);
            chk("R1 unmapped rvalid", 1, {21'h0, m_rvalid}, 24'h0);
        end

        // R11: reset drops an in-flight EEPROM read and clears memory
        @(negedge clk);
        drive(3'b100, 3'b000, 24'h85_00_00, 24'h0);
        #1;
        chk("R11 setup grant", 11, {21'h0, m_gnt}, 24'h00_00_04);
        @(negedge clk);
        rst = 1'b1;
        drive(3'b001, 3'b000, 24'h00_00_03, 24'h0);
        #1;
        chk("R11 gnt during reset", 11, {21'h0, m_gnt}, 24'h0);
        @(negedge clk);
        rst = 1'b0;
        drive(3'b000, 3'b000, 24'h0, 24'h0);
        for (int k = 0; k < 4; k++) begin
            #1;
            chk("R11 flushed rvalid", 11, {21'h0, m_rvalid}, 24'h0);
            @(negedge clk);
        end
        drive(3'b001, 3'b000, 24'h00_00_03, 24'h0);
        #1;
        chk("R11 post-reset grant", 11, {21'h0, m_gnt}, 24'h00_00_01);
        @(negedge clk);
        drive(3'b000, 3'b000, 24'h0, 24'h0);
        #1;
        chk("R11 post-reset rvalid", 11, {21'h0, m_rvalid}, 24'h00_00_01);
        chk("R11 cleared memory", 11, {16'h0, m_rdata[7:0]}, 24'h0);

        @(negedge clk);
        finish_run();
    end
endmodule